// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline with Operand Forwarding

This block is a small in-order processor pipeline with four stages: fetch, decode with operand read, operate, and write-back. Each pair of neighbouring stages is separated by a pipeline buffer with fixed contents. The fetch-to-decode buffer holds the instruction word. The decode-to-operate buffer holds both operand values, the operation code, the immediate and the destination register. The operate-to-write buffer holds the ALU result and the destination register.

Instruction words come from an instruction memory port. The port presents an address and returns the word in the same cycle, qualified by a ready signal. The block holds eight general registers and a single-cycle ALU. Each register write is visible on a debug port in the cycle it happens.

Hazard logic keeps a decoding instruction from using a stale register value. A parameter chooses between two variants. One forwards results from the newer in-flight instructions into the operands, so dependent instructions never wait. The other stalls decode until the producing result is being written.

Top module: `pipe4_core`

## Requirements
- R1: After reset the debug port shows no write, the fetch address is 0, and every register reads as 0.
- R2: Instruction encoding: bit 15 is the valid bit; bits 14:12 are the operation; bits 11:9 are the destination register; bits 8:6 and 5:3 are the first and second source registers. The operation codes are 0 add, 1 subtract (first minus second), 2 and, 3 or, 4 xor, 5 shift the first source left by one, 6 shift the first source right by one (logical), and 7 load immediate. Load immediate takes the zero-extended value of bits 8:0.
- R3: With the memory always ready and no waits, the result of the instruction fetched on clock edge k shows on the debug port after edge k+2. N such instructions therefore finish with the last write visible N+2 cycles after reset is released.
- R4: While the memory is not ready, the fetch address holds and a bubble enters decode. Each cycle of waiting delays completion by exactly one cycle.
- R5: A bubble, or a fetched word whose valid bit is clear, never writes a register and never shows on the debug port.
- R6: With forwarding enabled, an instruction that depends on the one just before it proceeds without a stall. A chain of N dependent instructions finishes in N+2 cycles.
- R7: With forwarding disabled, a dependence on the immediately preceding instruction costs one stall cycle. A chain of N dependent instructions finishes in 2N+1 cycles with correct results.
- R8: When two in-flight instructions both target a source register, the operand takes the newer result.
- R9: A register read in the same cycle that the register is written returns the new value.
- R10: A stall holds the fetch address and the fetch-to-decode buffer, and inserts a bubble into the operate stage.
- R11: For any program and any pattern of memory waits, the sequence of debug-port writes equals the writes of sequential execution, in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | AW | Address of the instruction being fetched |
| imem_rdata | input | 16 | Instruction word at imem_addr, same cycle |
| imem_ready | input | 1 | High when imem_rdata is valid this cycle |
| wb_valid | output | 1 | A register write happens this cycle |
| wb_rd | output | 3 | Register being written |
| wb_data | output | DW | Value being written |

## Verification
A result reaches the debug port three clock edges after its word is accepted at fetch. The edges are the fetch buffer, the operand buffer and the result buffer. Each stall or memory wait adds exactly one edge. The bench counts edges from reset release and records the count at which the last write shows. Directed programs then compare that count with N+2, 2N+1 or N+2 plus the wait count. Write values and order are checked at the falling edge after each write. A sequential model of the program computes the expected writes, so the result checks are the same whatever the memory timing. Two instances, one with forwarding and one without, run each program side by side.

// File: rtl/pipe4_pkg.sv
// Package: shared instruction format and operation codes for the pipeline.
// Assumes 8 architectural registers and a 16-bit instruction word.
package pipe4_pkg;

    localparam int IW   = 16;
    localparam int RA_W = 3;
    localparam int NREG = 1 << RA_W;
    localparam int IMMW = 9;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SHL = 3'd5,
        OP_SHR = 3'd6,
        OP_LDI = 3'd7
    } op_e;

    typedef struct packed {
        logic            valid;
        op_e             op;
        logic [RA_W-1:0] rd;
        logic [RA_W-1:0] rs1;
        logic [RA_W-1:0] rs2;
        logic [2:0]      lo;
    } instr_t;

    // True when the operation reads its first source register.
    function automatic logic reads_src1(op_e op);
        return op != OP_LDI;
    endfunction

    // True when the operation reads its second source register.
    function automatic logic reads_src2(op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
               (op == OP_OR)  || (op == OP_XOR);
    endfunction

endpackage

// File: rtl/pipe4_regfile.sv
// Register file: NREG words of DW bits, two combinational read ports, one
// synchronous write port. A read of the register being written this cycle
// returns the new value. Assumes synchronous active-low reset clears all words.
module pipe4_regfile #(
    parameter int DW   = 16,
    parameter int RA_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RA_W-1:0] wa,
    input  logic [DW-1:0]   wd,
    input  logic [RA_W-1:0] ra1,
    input  logic [RA_W-1:0] ra2,
    output logic [DW-1:0]   rd1,
    output logic [DW-1:0]   rd2
);
    localparam int NW = 1 << RA_W;

    logic [DW-1:0] words [NW];

    for (genvar i = 0; i < NW; i++) begin : g_word
        // Clear on reset, load when this word is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i] <= '0;
            else if (we && (wa == RA_W'(i)))
                words[i] <= wd;
        end

        AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (wa == RA_W'(i))) |=> $stable(words[i]))
            else $error("register changed without a write"); // R5
    end

    // Read ports with write-through bypass.
    always_comb begin
        rd1 = (we && (wa == ra1)) ? wd : words[ra1];
        rd2 = (we && (wa == ra2)) ? wd : words[ra2];
    end

endmodule

// File: rtl/pipe4_alu.sv
// Single-cycle ALU for the operate stage. Assumes DW is at least IMMW so the
// immediate fits after zero extension.
module pipe4_alu
    import pipe4_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e             op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [IMMW-1:0] imm,
    output logic [DW-1:0]   y
);
    // Select the result of the requested operation.
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SHL:  y = {a[DW-2:0], 1'b0};
            OP_SHR:  y = {1'b0, a[DW-1:1]};
            default: y = {{(DW-IMMW){1'b0}}, imm};
        endcase
    end

endmodule

// File: rtl/pipe4_hazard.sv
// Operand selection and stall decision for the decode stage. With FWD_EN set
// the operand takes the newest in-flight producer (operate stage, then write
// stage, then register file) and never stalls. With FWD_EN clear it stalls
// while the operate-stage instruction targets a source; the write stage is
// covered by the register file bypass.
module pipe4_hazard
    import pipe4_pkg::*;
#(
    parameter int DW     = 16,
    parameter bit FWD_EN = 1'b1
) (
    input  logic            dec_valid,
    input  op_e             dec_op,
    input  logic [RA_W-1:0] dec_rs1,
    input  logic [RA_W-1:0] dec_rs2,
    input  logic [DW-1:0]   rf_a,
    input  logic [DW-1:0]   rf_b,
    input  logic            ex_valid,
    input  logic [RA_W-1:0] ex_rd,
    input  logic [DW-1:0]   ex_y,
    input  logic            wr_valid,
    input  logic [RA_W-1:0] wr_rd,
    input  logic [DW-1:0]   wr_y,
    output logic [DW-1:0]   opnd_a,
    output logic [DW-1:0]   opnd_b,
    output logic            stall
);
    logic hit_a, hit_b;

    // Does the operate-stage instruction produce a source of the decoder.
    always_comb begin
        hit_a = ex_valid && reads_src1(dec_op) && (ex_rd == dec_rs1);
        hit_b = ex_valid && reads_src2(dec_op) && (ex_rd == dec_rs2);
    end

    if (FWD_EN) begin : g_fwd
        // Newest producer wins: operate, then write, then register file.
        always_comb begin
            if (ex_valid && (ex_rd == dec_rs1))      opnd_a = ex_y;
            else if (wr_valid && (wr_rd == dec_rs1)) opnd_a = wr_y;
            else                                     opnd_a = rf_a;
            if (ex_valid && (ex_rd == dec_rs2))      opnd_b = ex_y;
            else if (wr_valid && (wr_rd == dec_rs2)) opnd_b = wr_y;
            else                                     opnd_b = rf_b;
            stall = 1'b0;
        end
    end else begin : g_stall
        // No bypass from the ALU: wait one cycle for the write.
        always_comb begin
            opnd_a = rf_a;
            opnd_b = rf_b;
            stall  = dec_valid && (hit_a || hit_b);
        end
    end

endmodule

// File: rtl/pipe4_core.sv
// Four-stage in-order pipeline: fetch, decode/operand read, operate, write.
// Assumes the instruction memory returns the addressed word in the same cycle
// when imem_ready is high. The debug port shows the write-stage buffer, which
// is the register write taking effect at the next edge.
module pipe4_core
    import pipe4_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 8,
    parameter bit FWD_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [AW-1:0]   imem_addr,
    input  logic [IW-1:0]   imem_rdata,
    input  logic            imem_ready,
    output logic            wb_valid,
    output logic [RA_W-1:0] wb_rd,
    output logic [DW-1:0]   wb_data
);
    // Fetch state and fetch-to-decode buffer.
    logic [AW-1:0]   pc;
    instr_t          fd_instr;

    // Decode-to-operate buffer.
    logic            do_valid;
    op_e             do_op;
    logic [RA_W-1:0] do_rd;
    logic [DW-1:0]   do_a, do_b;
    logic [IMMW-1:0] do_imm;

    // Operate-to-write buffer.
    logic            ow_valid;
    logic [RA_W-1:0] ow_rd;
    logic [DW-1:0]   ow_y;

    // Combinational nets between submodules.
    logic [DW-1:0]   rf_a, rf_b, opnd_a, opnd_b, alu_y;
    logic            stall;

    assign imem_addr = pc;

    // Fetch: advance on a ready word, insert a bubble on a miss, hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            fd_instr <= '0;
        end else if (!stall) begin
            if (imem_ready) begin
                fd_instr <= instr_t'(imem_rdata);
                pc       <= pc + AW'(1);
            end else begin
                fd_instr <= '0;
            end
        end
    end

    pipe4_regfile #(.DW(DW), .RA_W(RA_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ow_valid),
        .wa    (ow_rd),
        .wd    (ow_y),
        .ra1   (fd_instr.rs1),
        .ra2   (fd_instr.rs2),
        .rd1   (rf_a),
        .rd2   (rf_b)
    );

    pipe4_hazard #(.DW(DW), .FWD_EN(FWD_EN)) u_hz (
        .dec_valid (fd_instr.valid),
        .dec_op    (fd_instr.op),
        .dec_rs1   (fd_instr.rs1),
        .dec_rs2   (fd_instr.rs2),
        .rf_a      (rf_a),
        .rf_b      (rf_b),
        .ex_valid  (do_valid),
        .ex_rd     (do_rd),
        .ex_y      (alu_y),
        .wr_valid  (ow_valid),
        .wr_rd     (ow_rd),
        .wr_y      (ow_y),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .stall     (stall)
    );

    // Decode: load operands and control, or a bubble on a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            do_valid <= 1'b0;
            do_op    <= OP_ADD;
            do_rd    <= '0;
            do_a     <= '0;
            do_b     <= '0;
            do_imm   <= '0;
        end else begin
            do_valid <= fd_instr.valid && !stall;
            do_op    <= fd_instr.op;
            do_rd    <= fd_instr.rd;
            do_a     <= opnd_a;
            do_b     <= opnd_b;
            do_imm   <= {fd_instr.rs1, fd_instr.rs2, fd_instr.lo};
        end
    end

    pipe4_alu #(.DW(DW)) u_alu (
        .op  (do_op),
        .a   (do_a),
        .b   (do_b),
        .imm (do_imm),
        .y   (alu_y)
    );

    // Operate: capture the ALU result and destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ow_valid <= 1'b0;
            ow_rd    <= '0;
            ow_y     <= '0;
        end else begin
            ow_valid <= do_valid;
            ow_rd    <= do_rd;
            ow_y     <= alu_y;
        end
    end

    assign wb_valid = ow_valid;
    assign wb_rd    = ow_rd;
    assign wb_data  = ow_y;

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(pc) && $stable(fd_instr)))
        else $error("stall did not freeze fetch and decode"); // R10
    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !do_valid)
        else $error("stall did not insert a bubble"); // R10
    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !imem_ready) |=> ($stable(pc) && !fd_instr.valid))
        else $error("fetch miss did not hold address"); // R4
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && imem_ready) |=> (pc == $past(pc) + AW'(1)))
        else $error("fetch did not advance"); // R3
    AST_RESULT_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        do_valid |=> (wb_valid && (wb_rd == $past(do_rd))))
        else $error("operate result not passed to write"); // R3

endmodule

// File: tb/pipe4_core_tb.sv
module pipe4_core_tb;
    localparam int DW = 16;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rdy = 1'b1;
    always #4 clk = ~clk;

    logic [15:0] mem [0:255];
    logic [AW-1:0] addr_f, addr_n;
    logic [15:0] rdata_f, rdata_n;
    logic wv_f, wv_n;
    logic [2:0] wr_f, wr_n;
    logic [DW-1:0] wd_f, wd_n;
    assign rdata_f = mem[addr_f];
    assign rdata_n = mem[addr_n];

    pipe4_core #(.DW(DW), .AW(AW), .FWD_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(addr_f), .imem_rdata(rdata_f),
        .imem_ready(rdy), .wb_valid(wv_f), .wb_rd(wr_f), .wb_data(wd_f));
    pipe4_core #(.DW(DW), .AW(AW), .FWD_EN(1'b0)) u_dut_nf (
        .clk(clk), .rst_n(rst_n), .imem_addr(addr_n), .imem_rdata(rdata_n),
        .imem_ready(rdy), .wb_valid(wv_n), .wb_rd(wr_n), .wb_data(wd_n));

    int ck_m = 0, fl_m = 0, ck_f = 0, fl_f = 0, ck_n = 0, fl_n = 0;
    int cyc = 0, idx_f = 0, idx_n = 0, last_f = 0, last_n = 0, exp_n = 0;
    logic [2:0]    exp_rd  [0:63];
    logic [DW-1:0] exp_dat [0:63];
    string cur_tag = "R11";

    // Edges since reset release.
    always @(posedge clk) begin
        if (rst_n) cyc = cyc + 1; else cyc = 0;
    end

    // Write stream of the forwarding instance (R11).
    always @(negedge clk) begin
        if (!rst_n) begin idx_f = 0; last_f = 0; end
        else if (wv_f) begin
            ck_f++;
            if (idx_f >= exp_n || wr_f !== exp_rd[idx_f % 64] || wd_f !== exp_dat[idx_f % 64]) begin
                fl_f++;
                $display("FAIL %s fwd write %0d: rd=%0d data=%h expected rd=%0d data=%h (count %0d)",
                         cur_tag, idx_f, wr_f, wd_f, exp_rd[idx_f % 64], exp_dat[idx_f % 64], exp_n);
            end
            idx_f++;
            last_f = cyc;
        end
    end

    // Write stream of the stalling instance (R11).
    always @(negedge clk) begin
        if (!rst_n) begin idx_n = 0; last_n = 0; end
        else if (wv_n) begin
            ck_n++;
            if (idx_n >= exp_n || wr_n !== exp_rd[idx_n % 64] || wd_n !== exp_dat[idx_n % 64]) begin
                fl_n++;
                $display("FAIL %s nofwd write %0d: rd=%0d data=%h expected rd=%0d data=%h (count %0d)",
                         cur_tag, idx_n, wr_n, wd_n, exp_rd[idx_n % 64], exp_dat[idx_n % 64], exp_n);
            end
            idx_n++;
            last_n = cyc;
        end
    end

    function automatic logic [15:0] enc(int op, int rd, int a, int b);
        return {1'b1, 3'(op), 3'(rd), 3'(a), 3'(b), 3'b000};
    endfunction
    function automatic logic [15:0] ldi(int rd, int imm);
        return {1'b1, 3'd7, 3'(rd), 9'(imm)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        ck_m++;
        if (!ok) begin
            fl_m++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Sequential model of the program (R2, R11).
    task automatic build_expected(input int len);
        logic [DW-1:0] r [8];
        for (int i = 0; i < 8; i++) r[i] = '0;
        exp_n = 0;
        for (int i = 0; i < len; i++) begin
            logic [15:0] w = mem[i];
            logic [DW-1:0] a = r[w[8:6]], b = r[w[5:3]], y;
            if (!w[15]) continue;
            case (w[14:12])
                3'd0: y = a + b;
                3'd1: y = a - b;
                3'd2: y = a & b;
                3'd3: y = a | b;
                3'd4: y = a ^ b;
                3'd5: y = a << 1;
                3'd6: y = a >> 1;
                default: y = DW'(w[8:0]);
            endcase
            r[w[11:9]] = y;
            exp_rd[exp_n] = w[11:9];
            exp_dat[exp_n] = y;
            exp_n++;
        end
    endtask

    task automatic run(input int len, input int mode, input int ecf, input int ecn, input string tag);
        cur_tag = tag;
        build_expected(len);
        rst_n = 1'b0;
        rdy = 1'b1;
        repeat (3) @(negedge clk);
        chk(!wv_f && !wv_n, "R1", "write visible in reset", int'(wv_f) + int'(wv_n), 0);
        chk(addr_f == 0 && addr_n == 0, "R1", "fetch address in reset", int'(addr_f) + int'(addr_n), 0);
        #1 rst_n = 1'b1;
        for (int c = 0; c < len * 4 + 16; c++) begin
            case (mode)
                0: rdy = 1'b1;
                1: rdy = ($urandom % 4) != 0;
                default: rdy = !(c >= 2 && c < 5);
            endcase
            @(negedge clk);
            #1;
        end
        chk(idx_f == exp_n, tag, "fwd write count", idx_f, exp_n);
        chk(idx_n == exp_n, tag, "nofwd write count", idx_n, exp_n);
        if (ecf > 0) chk(last_f == ecf, tag, "fwd completion cycle", last_f, ecf);
        if (ecn > 0) chk(last_n == ecn, tag, "nofwd completion cycle", last_n, ecn);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    initial begin
        // R1 R2: registers start at zero; every operation once.
        clear_mem();
        mem[0] = enc(3, 4, 5, 6);
        mem[1] = enc(4, 7, 0, 1);
        mem[2] = ldi(1, 9'h12D);
        mem[3] = ldi(2, 9'h0F3);
        mem[4] = enc(0, 3, 1, 2);
        mem[5] = enc(1, 4, 2, 1);
        mem[6] = enc(2, 5, 1, 2);
        mem[7] = enc(3, 6, 1, 2);
        mem[8] = enc(4, 7, 1, 2);
        mem[9] = enc(5, 3, 1, 0);
        mem[10] = enc(6, 4, 2, 0);
        run(11, 0, 0, 0, "R1 R2");

        // R3: independent loads, memory always ready: N+2.
        clear_mem();
        for (int i = 0; i < 8; i++) mem[i] = ldi(i, 40 + i);
        run(8, 0, 10, 10, "R3");

        // R4: three miss cycles delay completion by three.
        run(8, 2, 13, 13, "R4");

        // R6 R7 R10: dependent chain of eight.
        clear_mem();
        mem[0] = ldi(1, 3);
        for (int i = 1; i < 8; i++) mem[i] = enc(0, 1, 1, 1);
        run(8, 0, 10, 17, "R6 R7 R10");

        // R8 R9: newest producer wins; same-cycle write is read back.
        clear_mem();
        mem[0] = ldi(1, 1);
        mem[1] = ldi(1, 2);
        mem[2] = enc(0, 2, 1, 1);
        mem[3] = ldi(3, 7);
        mem[4] = ldi(5, 0);
        mem[5] = enc(0, 4, 3, 3);
        run(6, 0, 8, 9, "R8 R9");

        // R5: words with the valid bit clear never write.
        clear_mem();
        mem[0] = ldi(2, 5);
        mem[1] = 16'h7A00;
        mem[2] = enc(0, 3, 2, 2) & 16'h7FFF;
        mem[3] = enc(0, 4, 2, 2);
        mem[4] = 16'h0E48;
        mem[5] = enc(1, 6, 4, 2);
        run(6, 1, 0, 0, "R5");

        // R11: constrained random programs, random memory waits.
        for (int t = 0; t < 30; t++) begin
            clear_mem();
            for (int i = 0; i < 24; i++) begin
                if ($urandom % 10 == 0)
                    mem[i] = 16'($urandom) & 16'h7FFF;
                else if ($urandom % 3 == 0)
                    mem[i] = ldi($urandom % 8, $urandom % 512);
                else
                    mem[i] = enc($urandom % 7, $urandom % 8, $urandom % 8, $urandom % 8);
            end
            run(24, t % 2, 0, 0, "R11");
        end

        $display("TB_RESULT checks=%0d failures=%0d", ck_m + ck_f + ck_n, fl_m + fl_f + fl_n);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", ck_m + ck_f + ck_n + 1, fl_m + fl_f + fl_n + 1);
        $finish;
    end

endmodule